// File: doc/BRIEF.md
# Serial Auxiliary Converter Command Port

This block is a three-wire serial slave. It loads 16-bit command words into three code registers for auxiliary converters (9, 10 and 8 bits wide) and into a flag output that has a level and an enable. The host drives a frame line, a serial clock and a serial data line. All three pins are asynchronous to the system clock. The block synchronizes them and detects their edges in the system clock domain.

While the frame line is low, every falling edge of the serial clock shifts one bit, MSB first, into a 16-bit shift register. When the frame line rises, the low ten bits are offered as a shared data field. Three active-high select bits choose which code registers take that field; each register takes its own width from the low end. The same event sets the flag level and the flag enable. The enable stands in for a three-state driver, which lives outside the block.

For each converter a low-power indicator is raised whenever its stored code is all zeros or all ones.

Top module: `auxconv_cmd_port`

## Requirements
- R1: Serial data is shifted only on a falling edge of `cmd_sclk` while `cmd_frame` is low. Clock edges seen while `cmd_frame` is high leave the shift register unchanged.
- R2: Bits enter MSB first, and a load uses the last 16 bits received. Any earlier bits in a longer burst are discarded.
- R3: The data field is word bits 9..0. Converter A takes bits 8..0, converter B takes bits 9..0 and converter C takes bits 7..0.
- R4: Word bit 11 selects converter A, bit 12 selects converter B and bit 10 selects converter C. Selects are active high, and any combination loads the same data field at once.
- R5: A code register that is not selected keeps its value across a load.
- R6: On every load, word bit 15 sets `flag_level` and word bit 14 sets `flag_oe`, whatever the select bits hold.
- R7: Word bit 13 has no effect on any output.
- R8: `conv_sleep[0]`, `[1]` and `[2]` (converters A, B and C) are high exactly when that converter's code is all zeros or all ones.
- R9: While `rst_n` is low at a clock edge, all codes clear to zero and `flag_level` and `flag_oe` go low.
- R10: Outputs change only as a result of a rising edge of `cmd_frame`. Shifting alone never alters them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_frame | input | 1 | Frame line: low to shift, rising edge to load |
| cmd_sclk | input | 1 | Serial clock, sampled on its falling edge |
| cmd_sdata | input | 1 | Serial data, MSB first |
| conv_a_code | output | 9 | Converter A code |
| conv_b_code | output | 10 | Converter B code |
| conv_c_code | output | 8 | Converter C code |
| flag_level | output | 1 | Flag logic level |
| flag_oe | output | 1 | Flag driver enable |
| conv_sleep | output | 3 | Low-power indicators {C, B, A} |

## Verification
The assertions assume that the serial pins change slowly compared with the system clock, so that every level stays put for several system cycles. They also assume that the data pin is steady around each falling serial edge. Under these conditions the synchronized edges arrive in the same order as the pin edges. The directed stimulus holds every pin phase for four system clocks and changes data only while the serial clock is high. It raises the frame line only after the serial clock has settled high again.

// File: rtl/auxconv_pkg.sv
// Package: word layout and converter widths for the auxiliary command port.
// Assumes a 16-bit command word with the data field at the low end.
package auxconv_pkg;
    localparam int WORD_W   = 16;
    localparam int FIELD_W  = 10;
    localparam int CONV_A_W = 9;
    localparam int CONV_B_W = 10;
    localparam int CONV_C_W = 8;
    localparam int NUM_CONV = 3;
    // Control bit positions; a host decodes these, so they are fixed.
    localparam int SEL_C_BIT  = 10;
    localparam int SEL_A_BIT  = 11;
    localparam int SEL_B_BIT  = 12;
    localparam int FLAG_EN_BIT  = 14;
    localparam int FLAG_LVL_BIT = 15;

    typedef struct packed {
        logic               flag_lvl;
        logic               flag_en;
        logic [NUM_CONV-1:0] sel;      // {C, B, A}
        logic [FIELD_W-1:0] field;
    } cmd_t;
endpackage

// File: rtl/auxconv_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous pins.
// Assumes each pin is held for longer than STAGES system clocks.
module auxconv_sync #(
    parameter int          N        = 3,
    parameter int          STAGES   = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] q_sync
);
    logic [N-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: move each pin one flop deeper into the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else if (s == 0) stg[s] <= d_async;
                else stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/auxconv_shifter.sv
// Module: detects serial clock falls and frame rises, and shifts the command word.
// Assumes the inputs are already synchronized with equal delay.
module auxconv_shifter
    import auxconv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_s,
    input  logic sclk_s,
    input  logic sdata_s,
    output cmd_t cmd,
    output logic load_stb
);
    logic [WORD_W-1:0] word;
    logic sclk_q, frame_q;
    logic sclk_fall;

    // Purpose: remember the previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b1;
            frame_q <= 1'b1;
        end else begin
            sclk_q  <= sclk_s;
            frame_q <= frame_s;
        end
    end

    assign sclk_fall = sclk_q & ~sclk_s;
    assign load_stb  = frame_s & ~frame_q;

    // Purpose: shift one bit in, MSB first, on each falling serial edge inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) word <= '0;
        else if (sclk_fall && !frame_s) word <= {word[WORD_W-2:0], sdata_s};
    end

    assign cmd.flag_lvl = word[FLAG_LVL_BIT];
    assign cmd.flag_en  = word[FLAG_EN_BIT];
    assign cmd.sel      = {word[SEL_C_BIT], word[SEL_B_BIT], word[SEL_A_BIT]};
    assign cmd.field    = word[FIELD_W-1:0];

    p_frame_high_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_s && frame_q) |=> $stable(word));
    p_load_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb);
endmodule

// File: rtl/auxconv_code_reg.sv
// Module: one converter code register with its low-power indicator.
// Assumes W is no wider than the shared data field slice it receives.
module auxconv_code_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         sel,
    input  logic [W-1:0] data,
    output logic [W-1:0] code,
    output logic         sleep
);
    // Purpose: take the data slice when this converter is selected on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) code <= '0;
        else if (load && sel) code <= data;
    end

    // Purpose: flag the two lowest-power codes.
    assign sleep = (code == '0) || (&code);

    p_load_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && sel) |=> (code == $past(data)));
    p_unsel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && sel) |=> $stable(code));
endmodule

// File: rtl/auxconv_cmd_port.sv
// Module: top of the serial command port for three auxiliary converters and a flag.
// Assumes the serial pins are slow compared with clk (several cycles per level).
module auxconv_cmd_port
    import auxconv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_frame,
    input  logic                cmd_sclk,
    input  logic                cmd_sdata,
    output logic [CONV_A_W-1:0] conv_a_code,
    output logic [CONV_B_W-1:0] conv_b_code,
    output logic [CONV_C_W-1:0] conv_c_code,
    output logic                flag_level,
    output logic                flag_oe,
    output logic [NUM_CONV-1:0] conv_sleep
);
    logic [2:0] pins_s;
    cmd_t       cmd;
    logic       load_stb;

    auxconv_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({cmd_frame, cmd_sclk, cmd_sdata}),
        .q_sync(pins_s)
    );

    auxconv_shifter i_shift (
        .clk(clk), .rst_n(rst_n),
        .frame_s(pins_s[2]), .sclk_s(pins_s[1]), .sdata_s(pins_s[0]),
        .cmd(cmd), .load_stb(load_stb)
    );

    auxconv_code_reg #(.W(CONV_A_W)) i_conv_a (
        .clk(clk), .rst_n(rst_n), .load(load_stb), .sel(cmd.sel[0]),
        .data(cmd.field[CONV_A_W-1:0]), .code(conv_a_code), .sleep(conv_sleep[0])
    );
    auxconv_code_reg #(.W(CONV_B_W)) i_conv_b (
        .clk(clk), .rst_n(rst_n), .load(load_stb), .sel(cmd.sel[1]),
        .data(cmd.field[CONV_B_W-1:0]), .code(conv_b_code), .sleep(conv_sleep[1])
    );
    auxconv_code_reg #(.W(CONV_C_W)) i_conv_c (
        .clk(clk), .rst_n(rst_n), .load(load_stb), .sel(cmd.sel[2]),
        .data(cmd.field[CONV_C_W-1:0]), .code(conv_c_code), .sleep(conv_sleep[2])
    );

    // Purpose: update flag level and enable on every load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_level <= 1'b0;
            flag_oe    <= 1'b0;
        end else if (load_stb) begin
            flag_level <= cmd.flag_lvl;
            flag_oe    <= cmd.flag_en;
        end
    end

    p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |=> ($stable(flag_level) && $stable(flag_oe)));
    p_flag_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (flag_oe == $past(cmd.flag_en)));
endmodule

// File: tb/test_auxconv_cmd_port.sv
module test_auxconv_cmd_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame = 1'b1, sclk = 1'b1, sdata = 1'b0;
    logic [8:0] a_code;
    logic [9:0] b_code;
    logic [7:0] c_code;
    logic flag_level, flag_oe;
    logic [2:0] sleep;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    auxconv_cmd_port i_auxconv_cmd_port (
        .clk(clk), .rst_n(rst_n), .cmd_frame(frame), .cmd_sclk(sclk), .cmd_sdata(sdata),
        .conv_a_code(a_code), .conv_b_code(b_code), .conv_c_code(c_code),
        .flag_level(flag_level), .flag_oe(flag_oe), .conv_sleep(sleep)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Shift n bits of v, MSB first, with the frame already low.
    task automatic shift_bits(input int n, input logic [31:0] v);
        for (int i = n - 1; i >= 0; i--) begin
            sdata = v[i];
            wait_n(4);
            sclk = 1'b0;
            wait_n(4);
            sclk = 1'b1;
        end
        wait_n(4);
    endtask

    task automatic raise_frame();
        frame = 1'b1;
        wait_n(8);
    endtask

    task automatic send(input int n, input logic [31:0] v);
        frame = 1'b0;
        wait_n(4);
        shift_bits(n, v);
        raise_frame();
    endtask

    task automatic chk_all(input string req, input logic [8:0] a, input logic [9:0] b,
                           input logic [7:0] c, input logic fl, input logic oe);
        chk(req, {23'd0, a_code}, {23'd0, a});
        chk(req, {22'd0, b_code}, {22'd0, b});
        chk(req, {24'd0, c_code}, {24'd0, c});
        chk(req, {30'd0, flag_level, flag_oe}, {30'd0, fl, oe});
    endtask

    task automatic t_reset();
        chk_all("R9", 9'h0, 10'h0, 8'h0, 1'b0, 1'b0);
        chk("R8", {29'd0, sleep}, 32'h7);
    endtask

    task automatic t_single();
        send(16, 32'h0AA5);
        chk_all("R3", 9'h0A5, 10'h0, 8'h0, 1'b0, 1'b0);
        chk("R8", {29'd0, sleep}, 32'h6);
    endtask

    task automatic t_multi();
        send(16, 32'h1FC7);
        chk_all("R4", 9'h1C7, 10'h3C7, 8'hC7, 1'b0, 1'b0);
    endtask

    task automatic t_unsel();
        send(16, 32'h0412);
        chk_all("R5", 9'h1C7, 10'h3C7, 8'h12, 1'b0, 1'b0);
    endtask

    task automatic t_flag();
        send(16, 32'hC000);
        chk_all("R6", 9'h1C7, 10'h3C7, 8'h12, 1'b1, 1'b1);
        send(16, 32'h4000);
        chk_all("R6", 9'h1C7, 10'h3C7, 8'h12, 1'b0, 1'b1);
        send(16, 32'h8000);
        chk_all("R6", 9'h1C7, 10'h3C7, 8'h12, 1'b1, 1'b0);
    endtask

    task automatic t_bit13();
        send(16, 32'h2855);
        chk_all("R7", 9'h055, 10'h3C7, 8'h12, 1'b0, 1'b0);
    endtask

    task automatic t_sleep();
        send(16, 32'h1FFF);
        chk("R8", {29'd0, sleep}, 32'h7);
        send(16, 32'h1CFF);
        chk("R8", {29'd0, sleep}, 32'h4);
    endtask

    task automatic t_long_burst();
        send(20, 32'hF0801);
        chk_all("R2", 9'h001, 10'h0FF, 8'hFF, 1'b0, 1'b0);
    endtask

    task automatic t_no_early();
        frame = 1'b0;
        wait_n(4);
        shift_bits(16, 32'hDC33);
        chk_all("R10", 9'h001, 10'h0FF, 8'hFF, 1'b0, 1'b0);
        raise_frame();
        chk_all("R10", 9'h033, 10'h033, 8'h33, 1'b1, 1'b1);
    endtask

    task automatic t_frame_high();
        // Clock a different word while the frame is high; it must not enter.
        shift_bits(16, 32'h1C2A);
        frame = 1'b0;
        wait_n(4);
        raise_frame();
        chk_all("R1", 9'h033, 10'h033, 8'h33, 1'b1, 1'b1);
    endtask

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(4);
        t_reset();
        t_single();
        t_multi();
        t_unsel();
        t_flag();
        t_bit13();
        t_sleep();
        t_long_burst();
        t_no_early();
        t_frame_high();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule